// File: doc/BRIEF.md
# Serial Clock Generator with Two-Range Prescaler

This block turns the system clock into the serial clock of an SPI controller. A 5-bit prescale field selects the SCLK period. When its top bit is clear the low bits give the period directly in system clocks. When the top bit is set the period is twice the low bits, in steps of two. The block also applies the programmed polarity and phase, and it drives two one-cycle strobes into the shift engine next to it. The launch strobe tells the engine to put the next bit on the data line. The sample strobe tells it to capture the incoming bit.

A late-capture option moves the sample strobe to the SCLK edge opposite the one the phase setting would pick. This keeps sampling reliable at fast serial clocks. Every pin is a plain level: there is no data stream at this boundary, so none of the pins has a handshake.

All configuration inputs are registered before use, so each output follows its inputs by exactly one system clock. While `run` is low, SCLK rests at its idle level and no strobe is produced. A new prescale value is taken only at the start of a serial period. A period starts on the edge that leaves the idle level.

Top module: `spi_sclk_gen`

## Requirements
- R1: One cycle after `run` is sampled low, `sclk` equals the registered `cpol` and both strobes are low. During reset `sclk` is 0 and both strobes are low.
- R2: With `presc[4]`=0 and `presc[3:0]` from 2 to 15, the SCLK period is `presc[3:0]` system clocks.
- R3: With `presc[4]`=1 and `presc[3:0]` from 1 to 15, the SCLK period is 2×`presc[3:0]` system clocks. This gives 16 to 30 for low values 8 to 15.
- R4: Field values that give a divisor below 2 are raised to the fastest period of 2 system clocks. These are 0 and 1, and 16 (top bit set, low bits zero). Both strobes are still produced at this rate.
- R5: Each period begins with the active half, where `sclk` is not `cpol`, lasting ceil(N/2) clocks. The idle half, where `sclk` equals `cpol`, follows and lasts floor(N/2) clocks.
- R6: With `cpol`=1 the SCLK waveform is the inverse of the `cpol`=0 waveform, so it idles high.
- R7: The leading edge is the change into the active half; the trailing edge is the change back to the idle level. Each strobe is high for exactly one cycle, the cycle in which the `sclk` level after the matching edge is first visible. With `cpha`=0, `sample` pulses at the leading edge and `launch` at the trailing edge. With `cpha`=1 the two are swapped.
- R8: With `late_capture`=1, `sample` pulses on the edge opposite the one R7 gives, which is the same edge as `launch`.
- R9: A change of `presc` while running first affects the period that starts at the next leading edge. The period already in progress keeps its length.
- R10: When `run` is first sampled high, the leading edge and its strobe appear in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc | input | 5 | Prescale field: top bit selects the even-step range |
| cpol | input | 1 | Clock polarity, the idle level of SCLK |
| cpha | input | 1 | Clock phase: 0 samples on the leading edge |
| late_capture | input | 1 | Moves the sample strobe to the other edge |
| run | input | 1 | Run enable; low forces the idle level |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | One-cycle strobe to shift out the next bit |
| sample | output | 1 | One-cycle strobe to capture the incoming bit |

## Verification
Every output is a function of registers only. The result of inputs applied before clock edge k is therefore due in the cycle after edge k, and not later. The driver sets inputs one time unit after a rising edge. It queues each expected triple of `sclk`, `launch` and `sample` one edge later than the inputs it depends on. The monitor pops and compares one triple at each falling edge, so every comparison lands in the cycle where the value is due. The expected waveforms come from the period rules: active half ceil(N/2), idle half floor(N/2), and strobe edges chosen by phase and late capture. The bench also changes the prescale field after the first period has started, so the first period uses the old divisor and the later ones use the new divisor.

// File: rtl/spi_sclk_gen_pkg.sv
package spi_sclk_gen_pkg;

  typedef enum logic {
    EDGE_LEAD  = 1'b0,
    EDGE_TRAIL = 1'b1
  } sck_edge_e;

  function automatic logic pick_edge(input sck_edge_e sel, input logic lead, input logic trail);
    return (sel == EDGE_LEAD) ? lead : trail;
  endfunction

endpackage

// File: rtl/sck_div_decode.sv
module sck_div_decode #(
  parameter int FIELD_W = 5,
  localparam int CNT_W = FIELD_W
) (
  input  logic [FIELD_W-1:0] field,
  output logic [CNT_W-1:0]   half_hi,
  output logic [CNT_W-1:0]   half_lo
);
  logic [FIELD_W-2:0] low_bits;
  logic [CNT_W-1:0]   raw_div;
  logic [CNT_W-1:0]   eff_div;

  assign low_bits = field[FIELD_W-2:0];

  always_comb begin
    if (field[FIELD_W-1]) raw_div = {low_bits, 1'b0};
    else                  raw_div = {1'b0, low_bits};
    eff_div = (raw_div < CNT_W'(2)) ? CNT_W'(2) : raw_div;
    half_hi = (eff_div + CNT_W'(1)) >> 1;
    half_lo = eff_div >> 1;
  end
endmodule

// File: rtl/sck_phase_timer.sv
module sck_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_hi,
  input  logic [CNT_W-1:0] half_lo,
  output logic             lvl,
  output logic             lead_p,
  output logic             trail_p
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lo_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl     <= 1'b0;
      cnt     <= '0;
      lo_cur  <= '0;
      lead_p  <= 1'b0;
      trail_p <= 1'b0;
    end else if (!run) begin
      lvl     <= 1'b0;
      cnt     <= '0;
      lead_p  <= 1'b0;
      trail_p <= 1'b0;
    end else begin
      lead_p  <= 1'b0;
      trail_p <= 1'b0;
      if (!lvl && cnt == '0) begin
        lvl    <= 1'b1;
        cnt    <= half_hi - CNT_W'(1);
        lo_cur <= half_lo;
        lead_p <= 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end else begin
        lvl     <= 1'b0;
        cnt     <= lo_cur - CNT_W'(1);
        trail_p <= 1'b1;
      end
    end
  end

  // R1
  idle_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (!lvl && !lead_p && !trail_p));

  // R7
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_p, trail_p}));

  // R9
  period_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lo_cur) |-> lead_p);

  // R5
  active_half_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_p |-> ($past(lvl) && $past(cnt) == '0));
endmodule

// File: rtl/sck_strobe_map.sv
module sck_strobe_map
  import spi_sclk_gen_pkg::*;
(
  input  logic pha,
  input  logic late,
  input  logic lead_p,
  input  logic trail_p,
  output logic launch,
  output logic sample
);
  sck_edge_e launch_sel;
  sck_edge_e sample_sel;

  always_comb begin
    launch_sel = pha ? EDGE_LEAD : EDGE_TRAIL;
    sample_sel = (pha ^ late) ? EDGE_TRAIL : EDGE_LEAD;
    launch     = pick_edge(launch_sel, lead_p, trail_p);
    sample     = pick_edge(sample_sel, lead_p, trail_p);
  end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int FIELD_W = 5,
  localparam int CNT_W = FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] presc,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               late_capture,
  input  logic               run,
  output logic               sclk,
  output logic               launch,
  output logic               sample
);
  logic [CNT_W-1:0] half_hi;
  logic [CNT_W-1:0] half_lo;
  logic             lvl;
  logic             lead_p;
  logic             trail_p;
  logic             pol_q;
  logic             pha_q;
  logic             late_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      pha_q  <= 1'b0;
      late_q <= 1'b0;
    end else begin
      pol_q  <= cpol;
      pha_q  <= cpha;
      late_q <= late_capture;
    end
  end

  sck_div_decode #(.FIELD_W(FIELD_W)) u_dec (
    .field   (presc),
    .half_hi (half_hi),
    .half_lo (half_lo)
  );

  sck_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .half_hi (half_hi),
    .half_lo (half_lo),
    .lvl     (lvl),
    .lead_p  (lead_p),
    .trail_p (trail_p)
  );

  sck_strobe_map u_map (
    .pha     (pha_q),
    .late    (late_q),
    .lead_p  (lead_p),
    .trail_p (trail_p),
    .launch  (launch),
    .sample  (sample)
  );

  assign sclk = lvl ^ pol_q;

  // R7
  launch_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && $stable(pol_q)) |-> !$stable(sclk));

  // R8
  late_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && late_q) |-> launch);
endmodule

// File: tb/tb_spi_sclk_gen.sv
module tb_spi_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] presc = '0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       late_capture = 1'b0;
  logic       run = 1'b0;
  logic       sclk, launch, sample;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic  s;
    logic  l;
    logic  m;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t pend;
  bit   have_pend = 0;

  always #2 clk = ~clk;

  spi_sclk_gen dut (
    .clk(clk), .rst_n(rst_n), .presc(presc), .cpol(cpol), .cpha(cpha),
    .late_capture(late_capture), .run(run),
    .sclk(sclk), .launch(launch), .sample(sample)
  );

  function automatic int eff_div(input logic [4:0] f);
    int d;
    d = f[4] ? 2 * int'(f[3:0]) : int'(f[3:0]);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic cycle(input logic r, input logic [4:0] f, input logic pol,
                       input logic pha, input logic late, input exp_t e);
    @(posedge clk);
    #1;
    if (have_pend) q.push_back(pend);
    run = r; presc = f; cpol = pol; cpha = pha; late_capture = late;
    pend = e;
    have_pend = 1;
  endtask

  task automatic idle(input int n, input logic pol);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.s = pol; e.l = 1'b0; e.m = 1'b0; e.tag = "R1";
      cycle(1'b0, 5'd0, pol, 1'b0, 1'b0, e);
    end
  endtask

  task automatic burst(input logic [4:0] fa, input logic [4:0] fb, input int nper,
                       input logic pol, input logic pha, input logic late, input string tag);
    for (int p = 0; p < nper; p++) begin
      int n;
      int h;
      n = eff_div((p == 0) ? fa : fb);
      h = (n + 1) / 2;
      for (int k = 0; k < n; k++) begin
        exp_t e;
        logic lv, ld, tr;
        lv = (k < h); ld = (k == 0); tr = (k == h);
        e.s = lv ^ pol;
        e.l = pha ? ld : tr;
        e.m = (pha ^ late) ? tr : ld;
        e.tag = (p == 0 && k == 0) ? "R10" : tag;
        cycle(1'b1, (p == 0 && k == 0) ? fa : fb, pol, pha, late, e);
      end
    end
    idle(3, pol);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (sclk !== it.s || launch !== it.l || sample !== it.m) begin
        errors++;
        $display("FAIL %s: got sclk/launch/sample %b%b%b expected %b%b%b at %0t",
                 it.tag, sclk, launch, sample, it.s, it.l, it.m, $time);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sclk !== 1'b0 || launch !== 1'b0 || sample !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got %b%b%b expected 000", sclk, launch, sample);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2, 1'b0);
    burst(5'd4,  5'd4,  3, 1'b0, 1'b0, 1'b0, "R2");
    burst(5'd15, 5'd15, 2, 1'b0, 1'b0, 1'b0, "R2");
    burst(5'd5,  5'd5,  3, 1'b1, 1'b0, 1'b0, "R5");
    burst(5'd7,  5'd7,  2, 1'b1, 1'b1, 1'b0, "R6");
    burst(5'd0,  5'd0,  4, 1'b0, 1'b0, 1'b0, "R4");
    burst(5'd1,  5'd1,  3, 1'b0, 1'b1, 1'b0, "R4");
    burst(5'd16, 5'd16, 3, 1'b1, 1'b0, 1'b0, "R4");
    burst(5'h13, 5'h13, 2, 1'b0, 1'b0, 1'b0, "R3");
    burst(5'h1F, 5'h1F, 2, 1'b0, 1'b1, 1'b0, "R3");
    burst(5'd6,  5'd6,  2, 1'b0, 1'b1, 1'b0, "R7");
    burst(5'd7,  5'd7,  2, 1'b0, 1'b0, 1'b1, "R8");
    burst(5'd6,  5'd6,  2, 1'b1, 1'b1, 1'b1, "R8");
    burst(5'd0,  5'd0,  3, 1'b0, 1'b0, 1'b1, "R8");
    burst(5'd4,  5'd9,  3, 1'b0, 1'b0, 1'b0, "R9");
    burst(5'h18, 5'd3,  3, 1'b1, 1'b1, 1'b0, "R9");
    idle(2, 1'b0);
    @(posedge clk);
    #1;
    if (have_pend) q.push_back(pend);
    have_pend = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule